// File: doc/BRIEF.md
# Fractional Multiply-Accumulate-Round Unit

This block performs one fractional multiply-accumulate with rounding per clock. It keeps three 16-bit operand registers (X0, Y0, Y1) and two 36-bit accumulators (A and B). Each accumulator has 4 guard bits above a 32-bit fraction. When a command is issued, the unit picks one operand pair from a fixed menu. It multiplies the pair as signed fractions and can negate the product. It adds the product to the chosen accumulator, rounds the sum to the upper word and writes it back. It also updates a six-bit status word.

A simple load port fills any register so the unit can be seeded between operations. All state is registered, and a result appears at the outputs one clock after its command. Instruction decode, memory moves and saturation on transfers belong to surrounding logic.

Top module: `fmacr_unit`

## Requirements
- R1: The product of two 16-bit operands p and q is the signed product times two, as a 32-bit fraction sign-extended into 36 bits. The single exception is when both operands are 0x8000: the product is then 0x7FFFFFFF.
- R2: When `negate` is 1, the two's complement of the product is added instead of the product.
- R3: The `pair_sel` codes are 0=Y1·X0, 1=Y0·X0, 2=Y1·Y0, 3=Y0·Y0, 4=A1·Y0 and 5=B1·Y1. A1 and B1 are bits 31..16 of accumulator A and of accumulator B.
- R4: A command updates A when `dst_sel` is 0 and B when it is 1. The result is visible on `acc_a`/`acc_b` one clock after the command. The other accumulator does not change.
- R5: The sum is rounded at bit 15 by round-to-nearest, with ties going to even bit 16. Bits 15..0 of the result are then zero.
- R6: If the rounded result does not fit in 36 signed bits, it wraps modulo 2^36 and V (flags bit 0) is set.
- R7: N (bit 2) equals result bit 35. Z (bit 1) is set when the whole 36-bit result is zero.
- R8: E (bit 4) is set when bits 35..31 of the result are not all equal. U (bit 3) is set when bits 31 and 30 are equal.
- R9: L (bit 5) is set by any overflow and stays set until reset.
- R10: Flags change only on a legal command (`mac_en`=1 with `pair_sel` 0..5). `pair_sel` codes 6 and 7 change no register and no flag.
- R11: The load codes are `ld_sel` 0=X0, 1=Y0, 2=Y1, 3=A and 4=B. The word registers take `ld_data[15:0]`. Codes 5..7 have no effect, and a load is ignored while `mac_en` is 1.
- R12: Reset clears all registers and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_en | input | 1 | Issue a multiply-accumulate-round command |
| pair_sel | input | 3 | Operand pair code |
| negate | input | 1 | Subtract the product instead of adding it |
| dst_sel | input | 1 | Destination accumulator: 0=A, 1=B |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Load target code |
| ld_data | input | 36 | Load value |
| acc_a | output | 36 | Accumulator A |
| acc_b | output | 36 | Accumulator B |
| flags | output | 6 | {L,E,U,N,Z,V} status |

## Verification
The bench builds the unit with its default 16-bit words and 4 guard bits. At that size a 64-bit integer model holds every intermediate value exactly. The bench sweeps an 8-value corner set through all three operand registers, all six pairs, both signs and both destinations. Accumulators are reseeded near the positive and negative limits, which brings wraparound, the sticky limit flag and exact rounding ties within reach. A random phase and directed cases then cover the double minimum-value product, illegal codes and loads that collide with commands.

// File: rtl/fmacr_pkg.sv
package fmacr_pkg;
  typedef enum logic [2:0] {
    PAIR_Y1X0 = 3'd0,
    PAIR_Y0X0 = 3'd1,
    PAIR_Y1Y0 = 3'd2,
    PAIR_Y0Y0 = 3'd3,
    PAIR_A1Y0 = 3'd4,
    PAIR_B1Y1 = 3'd5
  } pair_e;

  localparam int NUM_PAIRS = 6;
  localparam int NUM_WREGS = 3;
  localparam int NUM_ACCS  = 2;

  localparam int FLG_V = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_U = 3;
  localparam int FLG_E = 4;
  localparam int FLG_L = 5;
  localparam int FLG_W = 6;
endpackage

// File: rtl/fmacr_regfile.sv
module fmacr_regfile #(
  parameter int DW = 16,
  parameter int EW = 4,
  localparam int AW = EW + 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [2:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_we,
  input  logic          acc_dst,
  input  logic [AW-1:0] acc_wdata,
  output logic [DW-1:0] x0,
  output logic [DW-1:0] y0,
  output logic [DW-1:0] y1,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b
);
  import fmacr_pkg::*;

  logic [DW-1:0] wreg_q [NUM_WREGS];
  logic [AW-1:0] acc_q  [NUM_ACCS];

  for (genvar i = 0; i < NUM_WREGS; i++) begin : g_wreg
    always_ff @(posedge clk) begin
      if (rst)
        wreg_q[i] <= '0;
      else if (ld_we && ld_sel == 3'(i))
        wreg_q[i] <= ld_data[DW-1:0];
    end
  end

  for (genvar k = 0; k < NUM_ACCS; k++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[k] <= '0;
      else if (acc_we && acc_dst == 1'(k))
        acc_q[k] <= acc_wdata;
      else if (ld_we && ld_sel == 3'(NUM_WREGS + k))
        acc_q[k] <= ld_data;
    end
  end

  assign x0    = wreg_q[0];
  assign y0    = wreg_q[1];
  assign y1    = wreg_q[2];
  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];
endmodule

// File: rtl/fmacr_datapath.sv
module fmacr_datapath #(
  parameter int DW = 16,
  parameter int EW = 4,
  localparam int AW = EW + 2 * DW,
  localparam int PW = 2 * DW,
  localparam int SW = AW + 2
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          negate,
  input  logic [AW-1:0] acc_in,
  output logic [AW-1:0] result,
  output logic          ovf
);
  localparam logic [DW-1:0] MIN_W = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] HALF  = {1'b1, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic [PW-1:0]        frac;
  logic [SW-1:0]        addend;
  logic [SW-1:0]        sum;
  logic [DW-1:0]        low;
  logic                 rnd_up;
  logic [SW-DW-1:0]     upper;
  logic [SW-1:0]        rounded;
  logic [SW-AW:0]       top_bits;

  always_comb begin
    prod = $signed(op_a) * $signed(op_b);
    if (op_a == MIN_W && op_b == MIN_W)
      frac = {1'b0, {(PW-1){1'b1}}};
    else
      frac = {prod[PW-2:0], 1'b0};
    addend = {{(SW-PW){frac[PW-1]}}, frac};
    if (negate)
      addend = -addend;
    sum      = {{(SW-AW){acc_in[AW-1]}}, acc_in} + addend;
    low      = sum[DW-1:0];
    rnd_up   = (low > HALF) || (low == HALF && sum[DW]);
    upper    = sum[SW-1:DW] + {{(SW-DW-1){1'b0}}, rnd_up};
    rounded  = {upper, {DW{1'b0}}};
    top_bits = rounded[SW-1:AW-1];
    ovf      = !((top_bits == '0) || (top_bits == '1));
    result   = rounded[AW-1:0];
  end
endmodule

// File: rtl/fmacr_flags.sv
module fmacr_flags #(
  parameter int DW = 16,
  parameter int EW = 4,
  localparam int AW = EW + 2 * DW,
  localparam int PW = 2 * DW
) (
  input  logic [AW-1:0]                  result,
  input  logic                           ovf,
  input  logic                           l_prev,
  output logic [fmacr_pkg::FLG_W-1:0]    flg
);
  import fmacr_pkg::*;

  logic [EW:0] ext_bits;

  always_comb begin
    ext_bits   = result[AW-1:PW-1];
    flg        = '0;
    flg[FLG_V] = ovf;
    flg[FLG_Z] = (result == '0);
    flg[FLG_N] = result[AW-1];
    flg[FLG_U] = (result[PW-1] == result[PW-2]);
    flg[FLG_E] = !((ext_bits == '0) || (ext_bits == '1));
    flg[FLG_L] = l_prev | ovf;
  end
endmodule

// File: rtl/fmacr_unit.sv
module fmacr_unit #(
  parameter int DW = 16,
  parameter int EW = 4,
  localparam int AW = EW + 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mac_en,
  input  logic [2:0]    pair_sel,
  input  logic          negate,
  input  logic          dst_sel,
  input  logic          ld_en,
  input  logic [2:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b,
  output logic [5:0]    flags
);
  import fmacr_pkg::*;

  logic [DW-1:0]    x0, y0, y1;
  logic [DW-1:0]    op_a, op_b;
  logic [AW-1:0]    acc_in, result;
  logic             ovf, legal, do_mac;
  logic [FLG_W-1:0] flg_d, flg_q;

  assign legal  = (int'(pair_sel) < NUM_PAIRS);
  assign do_mac = mac_en && legal;

  fmacr_regfile #(.DW(DW), .EW(EW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .ld_we    (ld_en && !mac_en),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .acc_we   (do_mac),
    .acc_dst  (dst_sel),
    .acc_wdata(result),
    .x0       (x0),
    .y0       (y0),
    .y1       (y1),
    .acc_a    (acc_a),
    .acc_b    (acc_b)
  );

  always_comb begin
    case (pair_sel)
      PAIR_Y1X0: begin op_a = y1; op_b = x0; end
      PAIR_Y0X0: begin op_a = y0; op_b = x0; end
      PAIR_Y1Y0: begin op_a = y1; op_b = y0; end
      PAIR_Y0Y0: begin op_a = y0; op_b = y0; end
      PAIR_A1Y0: begin op_a = acc_a[2*DW-1:DW]; op_b = y0; end
      PAIR_B1Y1: begin op_a = acc_b[2*DW-1:DW]; op_b = y1; end
      default:   begin op_a = '0; op_b = '0; end
    endcase
    acc_in = dst_sel ? acc_b : acc_a;
  end

  fmacr_datapath #(.DW(DW), .EW(EW)) u_dp (
    .op_a  (op_a),
    .op_b  (op_b),
    .negate(negate),
    .acc_in(acc_in),
    .result(result),
    .ovf   (ovf)
  );

  fmacr_flags #(.DW(DW), .EW(EW)) u_flg (
    .result(result),
    .ovf   (ovf),
    .l_prev(flg_q[FLG_L]),
    .flg   (flg_d)
  );

  always_ff @(posedge clk) begin
    if (rst)
      flg_q <= '0;
    else if (do_mac)
      flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/fmacr_chk.sv
module fmacr_chk #(
  parameter int DW = 16,
  parameter int EW = 4,
  localparam int AW = EW + 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          mac_en,
  input logic [2:0]    pair_sel,
  input logic          dst_sel,
  input logic [AW-1:0] acc_a,
  input logic [AW-1:0] acc_b,
  input logic [5:0]    flags
);
  logic legal_cmd;
  assign legal_cmd = mac_en && (pair_sel < 3'd6);

  // R9
  sticky_limit_chk: assert property (@(posedge clk) disable iff (rst)
    flags[5] |=> flags[5]);

  // R9
  ovf_sets_limit_chk: assert property (@(posedge clk) disable iff (rst)
    flags[0] |-> flags[5]);

  // R4
  keep_b_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_cmd && !dst_sel) |=> $stable(acc_b));

  // R4
  keep_a_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_cmd && dst_sel) |=> $stable(acc_a));

  // R5
  low_clear_a_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_cmd && !dst_sel) |=> (acc_a[DW-1:0] == '0));

  // R5
  low_clear_b_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_cmd && dst_sel) |=> (acc_b[DW-1:0] == '0));

  // R7
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_cmd && !dst_sel) |=> (flags[2] == acc_a[AW-1]));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (legal_cmd && dst_sel) |=> (flags[1] == (acc_b == '0)));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !legal_cmd |=> $stable(flags));

  // R10
  illegal_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_en && pair_sel >= 3'd6) |=> ($stable(acc_a) && $stable(acc_b)));
endmodule

bind fmacr_unit fmacr_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mac_en  (mac_en),
  .pair_sel(pair_sel),
  .dst_sel (dst_sel),
  .acc_a   (acc_a),
  .acc_b   (acc_b),
  .flags   (flags)
);

// File: tb/tb_fmacr_unit.sv
module tb_fmacr_unit;
  localparam int DW = 16;
  localparam int EW = 4;
  localparam int AW = EW + 2 * DW;
  localparam longint M36 = 64'sh0000_000F_FFFF_FFFF;
  localparam longint H35 = 64'sh0000_0008_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mac_en = 1'b0, negate = 1'b0, dst_sel = 1'b0, ld_en = 1'b0;
  logic [2:0] pair_sel = '0, ld_sel = '0;
  logic [AW-1:0] ld_data = '0;
  logic [AW-1:0] acc_a, acc_b;
  logic [5:0] flags;

  int total = 0, bad = 0;
  longint sx0 = 0, sy0 = 0, sy1 = 0, sa = 0, sb = 0;
  logic [5:0] sflg = '0;

  always #10 clk = ~clk;

  fmacr_unit #(.DW(DW), .EW(EW)) dut (
    .clk(clk), .rst(rst), .mac_en(mac_en), .pair_sel(pair_sel),
    .negate(negate), .dst_sel(dst_sel), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .acc_a(acc_a), .acc_b(acc_b), .flags(flags)
  );

  function automatic longint sx16(longint v);
    return ((v & 64'hFFFF) ^ 64'h8000) - 64'h8000;
  endfunction

  function automatic longint sx36(longint v);
    return ((v & M36) ^ H35) - H35;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk({28'd0, acc_a} == (sa & M36), {req, " acc_a"}, longint'(acc_a), sa & M36);
    chk({28'd0, acc_b} == (sb & M36), {req, " acc_b"}, longint'(acc_b), sb & M36);
    chk(flags == sflg, {req, " flags R7 R8 R9 R10"}, longint'(flags), longint'(sflg));
  endtask

  task automatic do_load(int sel, longint val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 3'(sel); ld_data = val[AW-1:0];
    @(negedge clk);
    ld_en = 1'b0;
    case (sel)
      0: sx0 = sx16(val);
      1: sy0 = sx16(val);
      2: sy1 = sx16(val);
      3: sa  = sx36(val);
      4: sb  = sx36(val);
      default: ;
    endcase
    check_state("R11 load");
  endtask

  // Expected result and flags follow R1..R10 using 64-bit integers.
  task automatic do_mac(int pair, bit neg, bit dst, string req,
                        bit with_ld = 1'b0, longint ldv = 0);
    longint a, b, p, s, low, base, res;
    bit v;
    a = 0; b = 0;
    case (pair)
      0: begin a = sy1; b = sx0; end
      1: begin a = sy0; b = sx0; end
      2: begin a = sy1; b = sy0; end
      3: begin a = sy0; b = sy0; end
      4: begin a = sx16(sa >>> 16); b = sy0; end
      5: begin a = sx16(sb >>> 16); b = sy1; end
      default: ;
    endcase
    if (a == -32768 && b == -32768) p = 64'sh7FFF_FFFF;
    else p = a * b * 2;
    if (neg) p = -p;
    s    = (dst ? sb : sa) + p;
    low  = s & 64'hFFFF;
    base = s - low;
    if (low > 32768 || (low == 32768 && ((s >>> 16) & 1) == 1)) base += 65536;
    v    = (base >= H35) || (base < -H35);
    res  = sx36(base);
    @(negedge clk);
    mac_en = 1'b1; pair_sel = 3'(pair); negate = neg; dst_sel = dst;
    ld_en = with_ld; ld_sel = 3'd0; ld_data = ldv[AW-1:0];
    @(negedge clk);
    mac_en = 1'b0; ld_en = 1'b0;
    if (pair < 6) begin
      if (dst) sb = res; else sa = res;
      sflg[0] = v;
      sflg[1] = (res == 0);
      sflg[2] = res < 0;
      sflg[3] = ((res >>> 31) & 1) == ((res >>> 30) & 1);
      sflg[4] = !(((res >>> 31) == 0) || ((res >>> 31) == -1));
      sflg[5] = sflg[5] | v;
    end
    check_state(req);
  endtask

  longint corners [8] = '{0, 1, -1, 32767, -32768, 16384, -16384, 4660};
  longint presets [8] = '{0, 64'sh8000, 64'sh1_8000, 64'sh7_FFFF_0000,
                          -H35, 64'sh7FFF_0000, -64'sh8000_0000, 64'sh4000_0000};

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_state("R12 reset");

    // R1: both operands at the minimum value
    do_load(0, 64'h8000); do_load(2, 64'h8000);
    do_mac(0, 1'b0, 1'b0, "R1 min*min");
    do_mac(0, 1'b1, 1'b1, "R2 negated min*min");

    // R5: ties round to even
    do_load(0, 0);
    do_load(3, 64'h0_0000_8000);
    do_mac(0, 1'b0, 1'b0, "R5 tie even-down");
    do_load(3, 64'h0_0001_8000);
    do_mac(0, 1'b0, 1'b0, "R5 tie odd-up");
    do_load(4, 64'h0_0001_8001);
    do_mac(1, 1'b0, 1'b1, "R5 above half");

    // R6 and R9: overflow wraps, limit stays after clean command
    do_load(0, 64'h7FFF); do_load(2, 64'h7FFF);
    do_load(3, 64'h7_FFFF_0000);
    do_mac(0, 1'b0, 1'b0, "R6 positive wrap");
    do_load(3, 0);
    do_mac(0, 1'b0, 1'b0, "R9 limit sticky");

    // R10: illegal codes change nothing
    do_mac(6, 1'b0, 1'b0, "R10 code 6");
    do_mac(7, 1'b1, 1'b1, "R10 code 7");

    // R11: load during command ignored, unused load codes ignored
    do_load(0, 64'h4000); do_load(2, 64'h4000); do_load(3, 0);
    do_mac(0, 1'b0, 1'b0, "R11 collide", 1'b1, 64'h0);
    do_mac(0, 1'b0, 1'b0, "R11 after collide");
    do_load(5, 64'h1234); do_load(7, 64'h5678);

    // R3 R4 R8: corner sweep over every pair, sign and destination
    for (int i = 0; i < 8; i++) begin
      do_load(3, presets[i]);
      do_load(4, presets[7 - i]);
      for (int j = 0; j < 8; j++) begin
        do_load(0, corners[i]);
        do_load(1, corners[j]);
        do_load(2, corners[(i + j) % 8]);
        for (int pr = 0; pr < 6; pr++)
          for (int n = 0; n < 2; n++)
            do_mac(pr, n[0], pr[0] ^ n[0], "R3 R4 sweep");
      end
    end

    // Random phase
    for (int k = 0; k < 1500; k++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3) do_load(r, longint'($urandom));
      else if (r == 3) do_load(3 + int'($urandom % 2),
                               {longint'($urandom % 16), 32'($urandom)});
      else do_mac(int'($urandom % 6), 1'($urandom), 1'($urandom), "R1 R2 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule